// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers six periodic timekeeping events and one alarm event into a bank of sticky flags. It drives a single interrupt request through a per-source enable mask and a master interrupt-enable bit. A small register bus reaches three locations: the status word, the mask, and a command word that holds the master enable. Reading the status word returns the pending flags and clears them, which also releases the interrupt request.

The events arrive as one-cycle pulses from the timekeeping logic. The block latches every event, whether or not its source is masked. Only the request output and the global flag in the top status bit depend on the mask. The request output is a logic-level enable for an external open-drain pull-down. While the output is high, the pull-down is on. The block behaves the same whichever supply domain the chip is running from.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags, the global flag, the mask and the master enable are zero, `irq_pull` is low and `bus_rdata` is zero.
- R2: A write to address 0x11 loads the mask from `bus_wdata[6:0]`, and bit 7 of that write is ignored. A write to address 0x12 loads the master enable from `bus_wdata[4]`. Reads return the mask as `{0, mask}` and the command word as `{000, enable, 0000}`.
- R3: An event pulse sets its flag at the next clock edge, whatever the mask holds. Periodic event i sets status bit i (i = 0..5), and the alarm sets status bit 6. A flag stays set until a status read clears it.
- R4: `irq_pull` is high exactly when the master enable is set and at least one flag has its mask bit set. It responds in the cycle after the edge that changes a flag, the mask or the enable.
- R5: A read strobe at address 0x10 captures the status word as it stood before the edge. That value appears on `bus_rdata` after the edge. The same edge clears flags 0..6 and the global flag.
- R6: Status bit 7 reads 1 when any flag has its mask bit set. Once set, it stays set until a status read, even if the mask is later cleared. Flags whose mask bit is clear never set it.
- R7: An event pulse in the same cycle as a clearing status read leaves that flag set after the clear.
- R8: Setting a mask bit for a flag that is already pending raises `irq_pull` in the cycle after the write, provided the enable is set.
- R9: `bus_rdata` holds the last read value until the next read strobe. Reads of an unmapped address return 0. Writes to the status address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_evt | input | 6 | One-cycle periodic event pulses, bit i goes to flag i |
| alarm_evt | input | 1 | One-cycle alarm event pulse |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| irq_pull | output | 1 | High to switch on the external open-drain pull-down |

## Verification
Each result has a fixed latency. Every event, write and clearing read takes effect at one clock edge, and `irq_pull` shows the new state right after that edge. Read data is likewise due one edge after its strobe, and it carries the status as it stood before that edge. The bench drives each stimulus just after a rising edge and waits for the next edge. It advances its reference model, then samples 1 ns later, so every comparison lands in the cycle where the result is due. Directed cases cover events that coincide with a clear, a mask enabled after a flag is already pending, a mask cleared after the global flag has set, and an ignored bit 7 of a mask write. A seeded random run then mixes all of these.

// File: rtl/tick_irq_pkg.sv
// Shared sizes and register addresses for the masked interrupt status controller.
package tick_irq_pkg;
    parameter int N_TICK  = 6;            // number of periodic event sources
    parameter int AW      = 5;            // register address width
    parameter int DW      = 8;            // register data width
    parameter int IEN_BIT = 4;            // position of the master enable in the command word
    localparam int NSRC   = N_TICK + 1;   // periodic sources plus the alarm
    localparam logic [AW-1:0] ADDR_STAT = 5'h10;
    localparam logic [AW-1:0] ADDR_MASK = 5'h11;
    localparam logic [AW-1:0] ADDR_CMD  = 5'h12;
endpackage

// File: rtl/tick_irq_flags.sv
// Sticky event flag bank.
// Each source has one flag, set by its pulse and cleared by a status read.
// A pulse in the clearing cycle wins over the clear.
// Assumes event pulses last one cycle and the clear strobe is already decoded.
module tick_irq_flags
    import tick_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr,
    output logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] flags_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Per-source flag: a pulse sets it, a clear resets it, and a pulse beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (evt[i])
                flags_q[i] <= 1'b1;
            else if (clr)
                flags_q[i] <= 1'b0;
        end
    end

    assign flags = flags_q;

    // R3: a pending flag survives until a clear
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R5 / R7: after a clear only the coincident events remain
    a_r7_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags_q == $past(evt)));
endmodule

// File: rtl/tick_irq_cfg.sv
// Configuration registers: the per-source mask and the master interrupt enable.
// Assumes the address is already compared, so each write strobe arrives pre-qualified.
module tick_irq_cfg
    import tick_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mask,
    input  logic            wr_cmd,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] mask,
    output logic            ien
);
    logic [NSRC-1:0] mask_q;
    logic            ien_q;

    // Mask register: only the source bits are stored and the top bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata[NSRC-1:0];
    end

    // Command register: only the master enable bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= 1'b0;
        else if (wr_cmd)
            ien_q <= wdata[IEN_BIT];
    end

    assign mask = mask_q;
    assign ien  = ien_q;

    // R2: the mask changes only on a mask write
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/tick_irq_gate.sv
// Mask and enable gating.
// Produces the request output and the sticky global flag that forms status bit 7.
// Assumes flags, mask and enable are registered, so the output is glitch-free per cycle.
module tick_irq_gate
    import tick_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] mask,
    input  logic            ien,
    input  logic            clr,
    output logic            gflag,
    output logic            irq
);
    logic hit;
    logic gflag_q;

    assign hit = |(flags & mask);

    // Global flag memory: holds a masked hit until the next status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gflag_q <= 1'b0;
        else if (clr)
            gflag_q <= 1'b0;
        else if (hit)
            gflag_q <= 1'b1;
    end

    assign gflag = gflag_q | hit;
    assign irq   = ien & hit;

    // R4: the request needs the master enable
    a_r4_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);
    // R6: the global flag only rises after a masked hit
    a_r6_gflag_from_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gflag_q) |-> $past(hit));
    // R6: an active request is always reflected in the global flag
    a_r6_irq_sets_gflag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gflag);
endmodule

// File: rtl/tick_irq_ctrl.sv
// Top level of the masked interrupt status controller.
// Decodes the register bus, reads status with clear-on-read, and registers the read data.
// Assumes bus strobes are one cycle wide and in the clk domain.
module tick_irq_ctrl
    import tick_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TICK-1:0] tick_evt,
    input  logic              alarm_evt,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_pull
);
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] mask;
    logic            ien;
    logic            gflag;
    logic            clr;
    logic            wr_mask;
    logic            wr_cmd;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   rdata_q;

    assign evt     = {alarm_evt, tick_evt};
    assign clr     = bus_rd & (bus_addr == ADDR_STAT);
    assign wr_mask = bus_wr & (bus_addr == ADDR_MASK);
    assign wr_cmd  = bus_wr & (bus_addr == ADDR_CMD);

    tick_irq_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .flags (flags)
    );

    tick_irq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_cmd  (wr_cmd),
        .wdata   (bus_wdata),
        .mask    (mask),
        .ien     (ien)
    );

    tick_irq_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags),
        .mask  (mask),
        .ien   (ien),
        .clr   (clr),
        .gflag (gflag),
        .irq   (irq_pull)
    );

    // Read selection: the pre-clear status, mask or command word by address.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_STAT: rd_mux = {{(DW-NSRC-1){1'b0}}, gflag, flags};
            ADDR_MASK: rd_mux = {{(DW-NSRC){1'b0}}, mask};
            ADDR_CMD:  rd_mux[IEN_BIT] = ien;
            default:   rd_mux = '0;
        endcase
    end

    // Read data register: loaded on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R9: read data is stable without a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));
endmodule

// File: tb/tick_irq_ctrl_test.sv
module tick_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] tick_evt;
    logic       alarm_evt;
    logic [4:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic       bus_rd;
    logic [7:0] bus_rdata;
    logic       irq_pull;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [6:0] m_flags;
    logic [6:0] m_mask;
    logic       m_ien;
    logic       m_g;
    logic [7:0] m_rdata;

    always #2 clk = ~clk;

    tick_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_evt(tick_evt), .alarm_evt(alarm_evt),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_pull(irq_pull)
    );

    function automatic logic exp_irq();
        return m_ien & (|(m_flags & m_mask));
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (a)
            5'h10:   return {m_g | (|(m_flags & m_mask)), m_flags};
            5'h11:   return {1'b0, m_mask};
            5'h12:   return {3'b000, m_ien, 4'b0000};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // one cycle: drive, advance model at the edge, sample 1 ns after
    task automatic cyc(input logic [5:0] t, input logic al, input logic wr, input logic rd,
                       input logic [4:0] a, input logic [7:0] wd, input string req);
        logic [7:0] rv;
        tick_evt = t; alarm_evt = al; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        rv = exp_read(a);
        if (rd) m_rdata = rv;
        m_g = m_g | (|(m_flags & m_mask));
        if (rd && a == 5'h10) begin
            m_flags = {al, t};
            m_g = 1'b0;
        end else begin
            m_flags = m_flags | {al, t};
        end
        if (wr && a == 5'h11) m_mask = wd[6:0];
        if (wr && a == 5'h12) m_ien = wd[4];
        #1;
        tick_evt = '0; alarm_evt = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        chk({req, " irq"}, {7'b0, irq_pull}, {7'b0, exp_irq()});
        if (rd) chk({req, " rdata"}, bus_rdata, m_rdata);
    endtask

    task automatic idle(input string req);
        cyc('0, 1'b0, 1'b0, 1'b0, 5'h00, 8'h00, req);
    endtask

    task automatic rd_reg(input logic [4:0] a, input string req);
        cyc('0, 1'b0, 1'b0, 1'b1, a, 8'h00, req);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input string req);
        cyc('0, 1'b0, 1'b1, 1'b0, a, d, req);
    endtask

    initial begin
        #100000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7170));
        rst_n = 1'b0; tick_evt = '0; alarm_evt = 1'b0; bus_addr = '0;
        bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        m_flags = '0; m_mask = '0; m_ien = 1'b0; m_g = 1'b0; m_rdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", {7'b0, irq_pull}, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        rd_reg(5'h10, "R1 status");
        rd_reg(5'h11, "R1 mask");
        rd_reg(5'h12, "R1 cmd");

        // R2: mask write with bit 7 ignored, command enable readback
        wr_reg(5'h11, 8'hFF, "R2 mask wr");
        rd_reg(5'h11, "R2 mask bit7 ignored");
        wr_reg(5'h12, 8'h10, "R2 cmd wr");
        rd_reg(5'h12, "R2 cmd rd");
        wr_reg(5'h11, 8'h00, "R2 mask clr");

        // R3: unmasked events still latch, with the bit mapping
        cyc(6'b000101, 1'b1, 1'b0, 1'b0, 5'h00, 8'h00, "R3 latch unmasked");
        idle("R3 hold");
        rd_reg(5'h10, "R3 status no gflag");
        rd_reg(5'h10, "R5 status cleared");

        // R8: a pending flag enabled later raises irq at once
        cyc(6'b001000, 1'b0, 1'b0, 1'b0, 5'h00, 8'h00, "R4 masked off");
        wr_reg(5'h11, 8'h08, "R8 late mask");
        // R6: the global flag stays set after the mask is cleared
        wr_reg(5'h11, 8'h00, "R4 mask drop");
        rd_reg(5'h10, "R6 sticky gflag");
        rd_reg(5'h10, "R6 cleared gflag");

        // R4: the enable gates the output
        wr_reg(5'h11, 8'h40, "R4 mask alarm");
        cyc('0, 1'b1, 1'b0, 1'b0, 5'h00, 8'h00, "R4 alarm irq");
        wr_reg(5'h12, 8'h00, "R4 ien off");
        wr_reg(5'h12, 8'h10, "R4 ien on");

        // R7: an event coincident with the clearing read survives
        cyc('0, 1'b1, 1'b0, 1'b1, 5'h10, 8'h00, "R7 coincident");
        rd_reg(5'h10, "R7 survived");

        // R9: unmapped read, ignored status write, held rdata
        wr_reg(5'h10, 8'hFF, "R9 status write ignored");
        rd_reg(5'h10, "R9 status after write");
        rd_reg(5'h05, "R9 unmapped");
        idle("R9 hold");
        chk("R9 rdata held", bus_rdata, m_rdata);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] t;
            logic       al;
            logic       wr;
            logic       rd;
            logic [4:0] a;
            logic [7:0] wd;
            t  = (($urandom % 4) == 0) ? 6'($urandom) : 6'b0;
            al = (($urandom % 8) == 0);
            wr = (($urandom % 6) == 0);
            rd = !wr && (($urandom % 5) == 0);
            case ($urandom % 5)
                0, 1:    a = 5'h10;
                2:       a = 5'h11;
                3:       a = 5'h12;
                default: a = 5'($urandom);
            endcase
            wd = 8'($urandom);
            cyc(t, al, wr, rd, a, wd, "R4 R5 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule